// File: doc/BRIEF.md
# Dual-Mode Serial Input Front End

This block is the serial loading path of a sixteen-channel LED driver. A host streams bits on a data pin with a shift strobe. A mode pin selects which holding register the stream is meant for: the 192-bit grayscale register, which holds sixteen 12-bit words, or the 96-bit dot-correction register, which holds sixteen 6-bit words. A rising edge on the latch strobe copies the shifted bits into the holding register that the mode selects. The serial output always presents the most significant bit of the active shift length, so several drivers can be chained in series.

After every grayscale update, the shift register is reloaded from a 192-bit status input port. The next shift sequence therefore pushes status bits out of the serial output, MSB first. After a dot-correction load, the first grayscale latch does not update the grayscale register at once. The update is held until one more shift-strobe pulse arrives. That pulse completes the update and shifts no data.

All four serial pins are treated as slow signals. Each passes through a parameterised synchroniser into the system clock domain. Their rising edges are then detected there, so every effect appears a fixed number of system clocks after the pin changes.

Top module: `sif_frontend`

## Requirements
- R1: When reset is asserted (synchronous, active high), the grayscale outputs, the dot-correction outputs and the serial output are all zero, and any pending extra-pulse condition is cleared. The first grayscale latch after reset therefore updates at once, even if a dot-correction load came before the reset.
- R2: In grayscale mode (mode pin = 0), each rising edge of the shift strobe moves the register up one place and enters the data pin at bit 0. The serial output equals bit 191, which is the bit entered 192 shift edges earlier.
- R3: In grayscale mode with no extra pulse pending, a rising latch edge copies the 192 shifted bits to the grayscale outputs. The first bit shifted (channel 15 bit 11) lands at output bit 191, and channel n occupies bits 12n+11 down to 12n. The dot-correction outputs stay unchanged.
- R4: Every grayscale update loads the status input into the shift register. Afterwards, in grayscale mode, the serial output shows status bit 191, and each further shift edge brings out the next lower status bit.
- R5: In dot-correction mode (mode pin = 1), the serial output equals bit 95, which is the bit entered 96 shift edges earlier. A rising latch edge copies shift bits 95..0 to the dot-correction outputs. It leaves the grayscale outputs and the shift contents unchanged.
- R6: After a dot-correction load, the next grayscale latch edge leaves the grayscale outputs unchanged. The following shift-strobe rising edge performs the grayscale update (with the status reload) and shifts no data. Any later grayscale latch updates at once. Two dot-correction loads in a row still need only one extra pulse.
- R7: Only rising edges act. A latch strobe held high causes one update, and shift edges during that time shift data normally without updating the grayscale outputs again. Falling edges have no effect.
- R8: Every pin change takes effect on the outputs within SYNC_STAGES + 2 system clock cycles. The data pin and mode pin are sampled with the same delay as the shift strobe, so they need only be valid when the strobe rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial shift strobe, acts on its rising edge |
| sin_i | input | 1 | Serial data in |
| mode_i | input | 1 | 0 = grayscale path, 1 = dot-correction path |
| xlat_i | input | 1 | Latch strobe, acts on its rising edge |
| status_i | input | 192 | Status word reloaded into the shift register on each grayscale update |
| sout_o | output | 1 | Serial data out (MSB of the active length) |
| gs_o | output | 192 | Grayscale holding register, channel n at bits 12n+11..12n |
| dc_o | output | 96 | Dot-correction holding register, channel n at bits 6n+5..6n |

## Verification
The hardest state to reach from the ports is the deferred grayscale update. It exists only between a grayscale latch edge that follows a dot-correction load and the next shift edge. Checks there must confirm that the outputs have not moved yet, and that the extra edge completes the update without consuming a data bit. The vector table orders its entries as dot-correction, dot-correction, grayscale, grayscale, so the bench passes through this state and also confirms that only one extra pulse is needed. A directed test asserts reset while the extra pulse is pending, to show that reset discards it.

// File: rtl/sif_pkg.sv
package sif_pkg;

  typedef enum logic {
    PATH_GS = 1'b0,
    PATH_DC = 1'b1
  } path_e;

  typedef struct packed {
    logic sclk;
    logic xlat;
    logic sin;
    logic mode;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sif_edge.sv
module sif_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

endmodule

// File: rtl/sif_latch_ctrl.sv
module sif_latch_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic sclk_rise,
  input  logic xlat_rise,
  input  logic mode_dc,
  output logic do_shift,
  output logic gs_update,
  output logic dc_update
);

  logic pend_q;   // extra pulse still owed after a dot-correction load
  logic wait_q;   // grayscale latch seen, waiting for the extra pulse

  always_comb begin
    do_shift  = 1'b0;
    gs_update = 1'b0;
    dc_update = 1'b0;
    if (xlat_rise) begin
      if (mode_dc)      dc_update = 1'b1;
      else if (!pend_q) gs_update = 1'b1;
    end else if (sclk_rise) begin
      if (wait_q) gs_update = 1'b1;
      else        do_shift  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
    end else if (dc_update) begin
      pend_q <= 1'b1;
      wait_q <= 1'b0;
    end else if (xlat_rise && !mode_dc && pend_q) begin
      wait_q <= 1'b1;
    end else if (sclk_rise && wait_q) begin
      wait_q <= 1'b0;
      pend_q <= 1'b0;
    end
  end

  // R6: the deferred state only exists while the extra pulse is owed
  p_wait_in_pend_r6: assert property (@(posedge clk) disable iff (rst)
    wait_q |-> pend_q);

  // R6: the owed pulse is discharged only by a shift edge in the wait state
  p_pend_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> $past(sclk_rise && wait_q));

  // R7: the three actions are mutually exclusive
  p_one_action_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_shift, gs_update, dc_update}));

endmodule

// File: rtl/sif_shift_reg.sv
module sif_shift_reg #(
  parameter int GS_W = 192,
  parameter int DC_W = 96
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            do_shift,
  input  logic            reload,
  input  logic            sin,
  input  logic            mode_dc,
  input  logic [GS_W-1:0] status,
  output logic [GS_W-1:0] sr,
  output logic            sout
);

  logic [GS_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (reload)   sr_q <= status;
    else if (do_shift) sr_q <= {sr_q[GS_W-2:0], sin};
  end

  assign sr   = sr_q;
  assign sout = mode_dc ? sr_q[DC_W-1] : sr_q[GS_W-1];

  // R2: a shift enters the data bit at position 0
  p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
    (do_shift && !reload) |=> (sr_q[0] == $past(sin)));

  // R4: a reload replaces the whole register with the status word
  p_sid_reload_r4: assert property (@(posedge clk) disable iff (rst)
    reload |=> (sr_q == $past(status)));

endmodule

// File: rtl/sif_frontend.sv
module sif_frontend #(
  parameter int CHANNELS    = 16,
  parameter int GS_BITS     = 12,
  parameter int DC_BITS     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sclk_i,
  input  logic                          sin_i,
  input  logic                          mode_i,
  input  logic                          xlat_i,
  input  logic [CHANNELS*GS_BITS-1:0]   status_i,
  output logic                          sout_o,
  output logic [CHANNELS*GS_BITS-1:0]   gs_o,
  output logic [CHANNELS*DC_BITS-1:0]   dc_o
);
  import sif_pkg::*;

  localparam int GS_W = CHANNELS * GS_BITS;
  localparam int DC_W = CHANNELS * DC_BITS;

  pins_t pins_raw, pins_s;
  logic [1:0] rise;
  logic sclk_rise, xlat_rise;
  logic do_shift, gs_update, dc_update;
  logic mode_dc;
  logic [GS_W-1:0] sr;
  logic [GS_W-1:0] gs_q;
  logic [DC_W-1:0] dc_q;

  assign pins_raw = '{sclk: sclk_i, xlat: xlat_i, sin: sin_i, mode: mode_i};

  sif_sync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  sif_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({pins_s.xlat, pins_s.sclk}),
    .rise (rise)
  );

  assign sclk_rise = rise[0];
  assign xlat_rise = rise[1];
  assign mode_dc   = (path_e'(pins_s.mode) == PATH_DC);

  sif_latch_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .xlat_rise (xlat_rise),
    .mode_dc   (mode_dc),
    .do_shift  (do_shift),
    .gs_update (gs_update),
    .dc_update (dc_update)
  );

  sif_shift_reg #(.GS_W(GS_W), .DC_W(DC_W)) u_sr (
    .clk      (clk),
    .rst      (rst),
    .do_shift (do_shift),
    .reload   (gs_update),
    .sin      (pins_s.sin),
    .mode_dc  (mode_dc),
    .status   (status_i),
    .sr       (sr),
    .sout     (sout_o)
  );

  always_ff @(posedge clk) begin
    if (rst)            gs_q <= '0;
    else if (gs_update) gs_q <= sr;
  end

  always_ff @(posedge clk) begin
    if (rst)            dc_q <= '0;
    else if (dc_update) dc_q <= sr[DC_W-1:0];
  end

  assign gs_o = gs_q;
  assign dc_o = dc_q;

  // R3: grayscale outputs move only on an update event
  p_gs_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !gs_update |=> $stable(gs_q));

  // R5: dot-correction outputs move only on a latch edge in that mode
  p_dc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(xlat_rise && mode_dc) |=> $stable(dc_q));

  // R5: a dot-correction latch leaves the shift contents untouched
  p_dc_keeps_sr_r5: assert property (@(posedge clk) disable iff (rst)
    dc_update |=> $stable(sr));

endmodule

// File: tb/sif_frontend_tb.sv
module sif_frontend_tb;

  localparam int GS_W = 192;
  localparam int DC_W = 96;

  typedef struct packed {
    logic        dc;
    logic [31:0] dseed;
    logic [31:0] sseed;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h1234_5678, 32'hA5A5_0F0F},
    '{1'b0, 32'hDEAD_BEEF, 32'h0000_0001},
    '{1'b1, 32'hCAFE_F00D, 32'h1111_2222},
    '{1'b1, 32'h0BAD_C0DE, 32'h3333_4444},
    '{1'b0, 32'h7777_1234, 32'h5555_6666},
    '{1'b0, 32'hFFFF_0000, 32'h7777_8888},
    '{1'b1, 32'h2468_ACE0, 32'h9999_AAAA},
    '{1'b0, 32'h1357_9BDF, 32'hBBBB_CCCC}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sin = 1'b0, mode = 1'b0, xlat = 1'b0;
  logic [GS_W-1:0] stat_cur = '0;
  logic sout;
  logic [GS_W-1:0] gs;
  logic [DC_W-1:0] dc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [GS_W-1:0] m_sr = '0;
  logic [GS_W-1:0] exp_gs = '0;
  logic [DC_W-1:0] exp_dc = '0;
  bit m_pend = 1'b0, m_wait = 1'b0;

  always #2.5 clk = ~clk;

  sif_frontend u_dut (
    .clk      (clk),
    .rst      (rst),
    .sclk_i   (sclk),
    .sin_i    (sin),
    .mode_i   (mode),
    .xlat_i   (xlat),
    .status_i (stat_cur),
    .sout_o   (sout),
    .gs_o     (gs),
    .dc_o     (dc)
  );

  function automatic logic [GS_W-1:0] gen(input logic [31:0] s);
    logic [GS_W-1:0] r;
    logic [31:0] x;
    x = s;
    r = '0;
    for (int i = 0; i < 6; i++) begin
      x = x * 32'h0019_660D + 32'h3C6E_F35F;
      r[i*32 +: 32] = x;
    end
    return r;
  endfunction

  function automatic logic exp_sout();
    return mode ? m_sr[DC_W-1] : m_sr[GS_W-1];
  endfunction

  task automatic chk(input string req, input logic [GS_W-1:0] act, input logic [GS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sin  = b;
    sclk = 1'b1;
    wait_n(5);
    sclk = 1'b0;
    wait_n(5);
    if (m_wait) begin
      exp_gs = m_sr;
      m_sr   = stat_cur;
      m_wait = 1'b0;
      m_pend = 1'b0;
    end else begin
      m_sr = {m_sr[GS_W-2:0], b};
    end
  endtask

  task automatic latch();
    xlat = 1'b1;
    wait_n(5);
    xlat = 1'b0;
    wait_n(5);
    if (mode) begin
      exp_dc = m_sr[DC_W-1:0];
      m_pend = 1'b1;
      m_wait = 1'b0;
    end else if (m_pend) begin
      m_wait = 1'b1;
    end else begin
      exp_gs = m_sr;
      m_sr   = stat_cur;
    end
  endtask

  task automatic shift_word(input logic [GS_W-1:0] data, input int n, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      pulse(data[n-1-i]);
      if (sout !== exp_sout()) bad++;
    end
    chk(req, GS_W'(bad), '0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sclk = 1'b0; xlat = 1'b0; sin = 1'b0;
    wait_n(4);
    rst = 1'b0;
    wait_n(4);
    m_sr = '0; exp_gs = '0; exp_dc = '0; m_pend = 1'b0; m_wait = 1'b0;
  endtask

  initial begin
    logic [GS_W-1:0] data;
    logic [GS_W-1:0] st;
    int n;
    bit was_pend;

    do_reset();
    // R1: reset state
    chk("R1 gs reset", gs, '0);
    chk("R1 dc reset", GS_W'(dc), '0);
    chk("R1 sout reset", GS_W'(sout), '0);

    for (int v = 0; v < NV; v++) begin
      data = gen(VEC[v].dseed);
      st   = gen(VEC[v].sseed);
      stat_cur = st;
      mode = VEC[v].dc;
      wait_n(5);
      n = VEC[v].dc ? DC_W : GS_W;
      shift_word(data, n, VEC[v].dc ? "R5 sout tap 95" : "R2 sout tap 191");
      if (VEC[v].dc) begin
        latch();
        chk("R5 dc load", GS_W'(dc), GS_W'(data[DC_W-1:0]));
        chk("R5 gs kept", gs, exp_gs);
        chk("R5 sout unchanged", GS_W'(sout), GS_W'(exp_sout()));
      end else begin
        was_pend = m_pend;
        latch();
        if (was_pend) begin
          chk("R6 gs held until extra pulse", gs, exp_gs);
          pulse(1'b1);
          chk("R6 gs after extra pulse", gs, data);
        end else begin
          chk("R3 gs immediate", gs, data);
        end
        chk("R3 dc kept", GS_W'(dc), GS_W'(exp_dc));
        chk("R4 sout status msb", GS_W'(sout), GS_W'(st[GS_W-1]));
        shift_word('0, 8, "R4 status shifts out");
      end
    end

    // R7: latch held high gives a single update; shifts still work
    mode = 1'b0;
    stat_cur = gen(32'h4242_4242);
    wait_n(5);
    data = gen(32'h600D_F00D);
    shift_word(data, GS_W, "R2 directed shift");
    xlat = 1'b1;
    wait_n(6);
    exp_gs = m_sr; m_sr = stat_cur;
    chk("R3 update with latch held", gs, data);
    sin = 1'b1;
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; wait_n(5); sclk = 1'b0; wait_n(5);
      m_sr = {m_sr[GS_W-2:0], 1'b1};
    end
    chk("R7 no second update while high", gs, data);
    chk("R7 shifts while latch high", GS_W'(sout), GS_W'(exp_sout()));
    xlat = 1'b0;
    wait_n(6);
    chk("R7 falling latch edge ignored", gs, data);
    chk("R7 sout after falling edge", GS_W'(sout), GS_W'(exp_sout()));

    // R8: effect visible within SYNC_STAGES+2 clocks of the strobe rise
    sin = 1'b0; sclk = 1'b1;
    wait_n(4);
    m_sr = {m_sr[GS_W-2:0], 1'b0};
    chk("R8 shift latency", GS_W'(sout), GS_W'(exp_sout()));
    sclk = 1'b0;
    wait_n(5);

    // R1: reset clears an owed extra pulse
    mode = 1'b1;
    wait_n(5);
    shift_word(gen(32'h0000_BEEF), DC_W, "R5 dc shift before reset");
    latch();
    chk("R5 dc load before reset", GS_W'(dc), GS_W'(exp_dc));
    do_reset();
    chk("R1 dc cleared", GS_W'(dc), '0);
    chk("R1 gs cleared", gs, '0);
    mode = 1'b0;
    stat_cur = gen(32'h0101_0101);
    wait_n(5);
    data = gen(32'h5A5A_5A5A);
    shift_word(data, GS_W, "R2 shift after reset");
    latch();
    chk("R1 no extra pulse after reset", gs, data);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule